// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is a three-wire serial slave that writes one of three configuration registers without any address or command bits. A host pulls the active-low enable low and clocks a bit stream in most significant bit first. When it releases the enable, the block looks at how many shift-clock rising edges arrived during the transfer. That count alone decides the action. The block can load an 8-bit configuration word, a 16-bit feedback divide ratio or a 15-bit reference divide ratio. It can also return all three registers to their reset values, or it can do nothing. Every write of the feedback divide ratio also raises a one-cycle jam-load strobe, which the divider counters use to restart together.

The serial pins are asynchronous to the block clock. The block synchronises them, detects their edges, and runs a four-state controller:
- `ST_IDLE` to `ST_SHIFT` when enable falls while the shift clock is low.
- `ST_IDLE` to `ST_LOCKOUT` when enable falls while the shift clock is high.
- `ST_SHIFT` to `ST_COMMIT` when enable rises while the shift clock is low.
- `ST_SHIFT` to `ST_LOCKOUT` when enable rises while the shift clock is high.
- `ST_COMMIT` to `ST_IDLE` after one cycle.
- `ST_LOCKOUT` to `ST_IDLE` once enable is high and the shift clock is low.

A serial data output carries the shift register's oldest bit, so a host can check the wiring by reading its own stream back.

Top module: `ldl_serial_loader`

## Requirements
- R1: Serial data is sampled on the rising shift-clock edge, and the first bit sent ends up as the most significant bit of the loaded field.
- R2: While enable is high, shift-clock edges shift nothing, `sdo_en` is 0, and the edge counter restarts from zero for the next transfer.
- R3: A transfer of exactly 8 edges loads `cfg_reg` with the last 8 bits sent.
- R4: A transfer of exactly 16 edges loads `fb_div` with the 16 bits sent. It also raises `jam_load` for exactly one clock cycle. No other transfer raises `jam_load`.
- R5: A transfer of 15 or 24 edges loads `ref_div` with the last 15 bits sent. In a 24-edge transfer the 9 leading bits are dropped.
- R6: A transfer of 9 to 13 edges is a soft reset: `cfg_reg` becomes 8'h10, and `fb_div` and `ref_div` become 0.
- R7: Any other count (0 to 7, 14, 17 to 23, 25 to 32, or above 32) changes no register. The edge counter saturates at 33, so a long stream cannot wrap into a valid length.
- R8: The registers keep their old values during shifting and change only after enable rises.
- R9: On each falling shift-clock edge, `sdo` takes the bit that is 16 positions back in the stream. After the k-th rising edge, for k of 16 or more, `sdo` shows bit number k-15. While enable is low, `sdo_en` is 1.
- R10: After reset, `cfg_reg` is 8'h10 (reference-output select field in bits 4:2 = 3'b100, all other bits 0). After reset, `fb_div`, `ref_div`, `jam_load`, `sdo` and `sdo_en` are all 0.
- R11: If enable changes while the shift clock is high, the transfer is discarded. The port then ignores everything until enable is high and the shift clock is low, and the next transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial pins are oversampled against it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Active-low serial enable |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out for loop-back |
| sdo_en | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| cfg_reg | output | 8 | Configuration register |
| fb_div | output | 16 | Feedback divide register |
| ref_div | output | 15 | Reference divide register |
| jam_load | output | 1 | One-cycle counter reload strobe after a feedback write |

## Verification
The bench uses the default parameters: 8-, 16- and 15-bit registers, reset window 9 to 13, counter saturation at 33, and two synchroniser stages. It holds each shift-clock half-period for six block clocks. With these values it can sweep every transfer length from 0 to 40 edges, plus 56 and 64, with fresh data each time. That sweep reaches every decode branch, the reserved lengths and the counter saturation. Every transfer of 16 edges or more also checks the loop-back bits. Separate directed sequences cover shift-clock edges while enable is high and enable edges while the shift clock is high.

// File: rtl/ldl_pkg.sv
package ldl_pkg;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_LOCKOUT
    } ldl_state_e;

    // Action selected from the transfer length.
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_CFG,
        ACT_FB,
        ACT_REF,
        ACT_RST
    } ldl_act_e;

    // Reference-output select field inside the configuration word.
    localparam int unsigned REFSEL_LSB  = 2;
    localparam logic [2:0]  REFSEL_DIV8 = 3'b100;

endpackage

// File: rtl/ldl_sync.sv
module ldl_sync #(
    parameter int unsigned      STAGES = 2,
    parameter int unsigned      WIDTH  = 3,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= INIT;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ldl_shifter.sv
module ldl_shifter #(
    parameter int unsigned SHIFT_W = 16,
    parameter int unsigned CNT_SAT = 33,
    parameter int unsigned CW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               fall_en,
    input  logic               din,
    output logic [SHIFT_W-1:0] shreg,
    output logic [CW-1:0]      cnt,
    output logic               sdo
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            sdo   <= 1'b0;
        end else if (clear) begin
            // The shift register keeps its contents; only the count and output restart.
            cnt <= '0;
            sdo <= 1'b0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[SHIFT_W-2:0], din};
                if (cnt != CW'(CNT_SAT)) begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (fall_en) begin
                sdo <= shreg[SHIFT_W-1];
            end
        end
    end

endmodule

// File: rtl/ldl_len_decode.sv
module ldl_len_decode
    import ldl_pkg::*;
#(
    parameter int unsigned CW           = 6,
    parameter int unsigned CFG_LEN      = 8,
    parameter int unsigned FB_LEN       = 16,
    parameter int unsigned REF_LEN      = 15,
    parameter int unsigned REF_LONG_LEN = 24,
    parameter int unsigned RST_MIN      = 9,
    parameter int unsigned RST_MAX      = 13
) (
    input  logic [CW-1:0] cnt,
    output ldl_act_e      act
);

    always_comb begin
        act = ACT_NONE;
        if (cnt == CW'(CFG_LEN)) begin
            act = ACT_CFG;
        end else if (cnt == CW'(FB_LEN)) begin
            act = ACT_FB;
        end else if ((cnt == CW'(REF_LEN)) || (cnt == CW'(REF_LONG_LEN))) begin
            act = ACT_REF;
        end else if ((cnt >= CW'(RST_MIN)) && (cnt <= CW'(RST_MAX))) begin
            act = ACT_RST;
        end
    end

endmodule

// File: rtl/ldl_regfile.sv
module ldl_regfile
    import ldl_pkg::*;
#(
    parameter int unsigned CFG_W   = 8,
    parameter int unsigned FB_W    = 16,
    parameter int unsigned REF_W   = 15,
    parameter int unsigned SHIFT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  ldl_act_e           act,
    input  logic [SHIFT_W-1:0] shreg,
    output logic [CFG_W-1:0]   cfg_q,
    output logic [FB_W-1:0]    fb_q,
    output logic [REF_W-1:0]   rdiv_q,
    output logic               jam_q
);

    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(REFSEL_DIV8) << REFSEL_LSB;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            fb_q   <= '0;
            rdiv_q <= '0;
            jam_q  <= 1'b0;
        end else begin
            jam_q <= 1'b0;
            if (commit) begin
                unique case (act)
                    ACT_CFG: cfg_q <= shreg[CFG_W-1:0];
                    ACT_FB: begin
                        fb_q  <= shreg[FB_W-1:0];
                        jam_q <= 1'b1;
                    end
                    ACT_REF: rdiv_q <= shreg[REF_W-1:0];
                    ACT_RST: begin
                        cfg_q  <= CFG_RST;
                        fb_q   <= '0;
                        rdiv_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ldl_serial_loader.sv
module ldl_serial_loader
    import ldl_pkg::*;
#(
    parameter int unsigned CFG_W        = 8,
    parameter int unsigned FB_W         = 16,
    parameter int unsigned REF_W        = 15,
    parameter int unsigned REF_LONG_LEN = 24,
    parameter int unsigned RST_MIN      = 9,
    parameter int unsigned RST_MAX      = 13,
    parameter int unsigned CNT_SAT      = 33,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sen_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_en,
    output logic [CFG_W-1:0] cfg_reg,
    output logic [FB_W-1:0]  fb_div,
    output logic [REF_W-1:0] ref_div,
    output logic             jam_load
);

    localparam int unsigned SHIFT_W_A = (FB_W > REF_W) ? FB_W : REF_W;
    localparam int unsigned SHIFT_W   = (SHIFT_W_A > CFG_W) ? SHIFT_W_A : CFG_W;
    localparam int unsigned CW        = $clog2(CNT_SAT + 1);

    // Synchronised pins and their values one cycle earlier.
    logic [2:0] pins_s;
    logic       sen_s, sclk_s, sdi_s;
    logic       sen_p, sclk_p;
    logic       sclk_rise, sclk_fall;

    ldl_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .INIT   (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sen_n, sclk, sdi}),
        .q     (pins_s)
    );

    assign {sen_s, sclk_s, sdi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sen_p  <= 1'b1;
            sclk_p <= 1'b0;
        end else begin
            sen_p  <= sen_s;
            sclk_p <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_p;
    assign sclk_fall = ~sclk_s & sclk_p;

    // Controller.
    ldl_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!sen_s) begin
                    st_d = sclk_s ? ST_LOCKOUT : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sen_s) begin
                    st_d = sclk_s ? ST_LOCKOUT : ST_COMMIT;
                end
            end
            ST_COMMIT: st_d = ST_IDLE;
            ST_LOCKOUT: begin
                if (sen_s && !sclk_s) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    logic clear, shift_en, fall_en, commit;

    always_comb begin
        clear    = 1'b0;
        shift_en = 1'b0;
        fall_en  = 1'b0;
        commit   = 1'b0;
        sdo_en   = 1'b0;
        unique case (st_q)
            ST_IDLE:    clear = 1'b1;
            ST_SHIFT: begin
                shift_en = sclk_rise & ~sen_s;
                fall_en  = sclk_fall & ~sen_s;
                sdo_en   = 1'b1;
            end
            ST_COMMIT:  commit = 1'b1;
            ST_LOCKOUT: clear = 1'b1;
            default:    clear = 1'b1;
        endcase
    end

    // Datapath.
    logic [SHIFT_W-1:0] shreg;
    logic [CW-1:0]      cnt;
    ldl_act_e           act;

    ldl_shifter #(
        .SHIFT_W (SHIFT_W),
        .CNT_SAT (CNT_SAT),
        .CW      (CW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .fall_en  (fall_en),
        .din      (sdi_s),
        .shreg    (shreg),
        .cnt      (cnt),
        .sdo      (sdo)
    );

    ldl_len_decode #(
        .CW           (CW),
        .CFG_LEN      (CFG_W),
        .FB_LEN       (FB_W),
        .REF_LEN      (REF_W),
        .REF_LONG_LEN (REF_LONG_LEN),
        .RST_MIN      (RST_MIN),
        .RST_MAX      (RST_MAX)
    ) u_dec (
        .cnt (cnt),
        .act (act)
    );

    ldl_regfile #(
        .CFG_W   (CFG_W),
        .FB_W    (FB_W),
        .REF_W   (REF_W),
        .SHIFT_W (SHIFT_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .act    (act),
        .shreg  (shreg),
        .cfg_q  (cfg_reg),
        .fb_q   (fb_div),
        .rdiv_q (ref_div),
        .jam_q  (jam_load)
    );

endmodule

// File: rtl/ldl_serial_loader_chk.sv
module ldl_serial_loader_chk
    import ldl_pkg::*;
#(
    parameter int unsigned CFG_W   = 8,
    parameter int unsigned FB_W    = 16,
    parameter int unsigned REF_W   = 15,
    parameter int unsigned SHIFT_W = 16,
    parameter int unsigned CNT_SAT = 33,
    parameter int unsigned CW      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input ldl_state_e         st_q,
    input ldl_act_e           act,
    input logic [CW-1:0]      cnt,
    input logic [SHIFT_W-1:0] shreg,
    input logic               sclk_fall,
    input logic               sdo,
    input logic               jam_load,
    input logic [CFG_W-1:0]   cfg_reg,
    input logic [FB_W-1:0]    fb_div,
    input logic [REF_W-1:0]   ref_div
);

    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(REFSEL_DIV8) << REFSEL_LSB;

    p_cfg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q == ST_COMMIT && act == ACT_CFG) |-> cfg_reg == $past(shreg[CFG_W-1:0]));

    p_jam_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jam_load |=> !jam_load);

    p_jam_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jam_load |-> ($past(st_q == ST_COMMIT && act == ACT_FB) && fb_div == $past(shreg[FB_W-1:0])));

    p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q == ST_COMMIT && act == ACT_RST) |-> (cfg_reg == CFG_RST && fb_div == '0 && ref_div == '0));

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CNT_SAT));

    p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q == ST_COMMIT) |-> ($stable(cfg_reg) && $stable(fb_div) && $stable(ref_div)));

    p_sdo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && $past(st_q == ST_SHIFT) && !$past(sclk_fall)) |-> $stable(sdo));

    p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q == ST_IDLE)) |-> cnt == '0);

endmodule

bind ldl_serial_loader ldl_serial_loader_chk #(
    .CFG_W   (CFG_W),
    .FB_W    (FB_W),
    .REF_W   (REF_W),
    .SHIFT_W (SHIFT_W),
    .CNT_SAT (CNT_SAT),
    .CW      (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .act       (act),
    .cnt       (cnt),
    .shreg     (shreg),
    .sclk_fall (sclk_fall),
    .sdo       (sdo),
    .jam_load  (jam_load),
    .cfg_reg   (cfg_reg),
    .fb_div    (fb_div),
    .ref_div   (ref_div)
);

// File: tb/sim_ldl_serial_loader.sv
module sim_ldl_serial_loader;

    localparam int HALF = 6;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sen_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_en, jam_load;
    logic [7:0]  cfg_reg;
    logic [15:0] fb_div;
    logic [14:0] ref_div;

    int checks = 0;
    int errors = 0;
    int jam_cnt = 0;
    int jam_wide = 0;
    logic jam_prev = 1'b0;

    // Reference model of the three registers.
    logic [7:0]  m_cfg = 8'h10;
    logic [15:0] m_fb = '0;
    logic [14:0] m_ref = '0;
    int          m_jam = 0;
    logic [63:0] seed = 64'h0123_4567_89ab_cdef;

    always #10 clk = ~clk;

    ldl_serial_loader u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen_n    (sen_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .sdo      (sdo),
        .sdo_en   (sdo_en),
        .cfg_reg  (cfg_reg),
        .fb_div   (fb_div),
        .ref_div  (ref_div),
        .jam_load (jam_load)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (jam_load) jam_cnt++;
            if (jam_load && jam_prev) jam_wide++;
        end
        jam_prev <= jam_load;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Clock n bits MSB first; optionally check the loop-back output (R9).
    task automatic clock_bits(input int n, input logic [63:0] d, input bit lb);
        for (int k = 0; k < n; k++) begin
            sdi = d[n-1-k];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            if (lb && k >= 15) begin
                check("R9", {31'd0, sdo}, {31'd0, d[n-1-(k-15)]});
                check("R9", {31'd0, sdo_en}, 32'd1);
            end
        end
    endtask

    // 0 none, 1 cfg, 2 feedback, 3 reference, 4 soft reset.
    function automatic int act_of(input int n);
        if (n == 8) return 1;
        if (n == 16) return 2;
        if (n == 15 || n == 24) return 3;
        if (n >= 9 && n <= 13) return 4;
        return 0;
    endfunction

    task automatic xfer(input int n, input logic [63:0] d);
        string tag;
        sen_n = 1'b0;
        repeat (HALF) @(negedge clk);
        clock_bits(n, d, 1'b1);
        // R8: nothing has changed before enable rises
        check("R8", {24'd0, cfg_reg}, {24'd0, m_cfg});
        check("R8", {16'd0, fb_div}, {16'd0, m_fb});
        check("R8", {17'd0, ref_div}, {17'd0, m_ref});
        sen_n = 1'b1;
        repeat (12) @(negedge clk);
        case (act_of(n))
            1: begin m_cfg = d[7:0]; tag = "R3"; end
            2: begin m_fb = d[15:0]; m_jam++; tag = "R4"; end
            3: begin m_ref = d[14:0]; tag = "R5"; end
            4: begin m_cfg = 8'h10; m_fb = '0; m_ref = '0; tag = "R6"; end
            default: tag = "R7";
        endcase
        check(tag, {24'd0, cfg_reg}, {24'd0, m_cfg});
        check(tag, {16'd0, fb_div}, {16'd0, m_fb});
        check(tag, {17'd0, ref_div}, {17'd0, m_ref});
        check(tag, jam_cnt, m_jam);
        check("R2", {31'd0, sdo_en}, 32'd0);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10", {24'd0, cfg_reg}, 32'h10);
        check("R10", {16'd0, fb_div}, 32'd0);
        check("R10", {17'd0, ref_div}, 32'd0);
        check("R10", {31'd0, jam_load}, 32'd0);
        check("R10", {31'd0, sdo}, 32'd0);
        check("R10", {31'd0, sdo_en}, 32'd0);

        // R1: first bit sent lands in the MSB
        xfer(8, 64'hA5);
        check("R1", {24'd0, cfg_reg}, 32'hA5);

        // Sweep of transfer lengths (R3..R7, R9)
        for (int n = 0; n <= 40; n++) begin
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            xfer(n, seed);
        end
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        xfer(56, seed);
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        xfer(64, seed);
        xfer(16, 64'h0000_0000_0000_BEEF);
        xfer(24, 64'h0000_0000_00FF_7123);
        check("R5", {17'd0, ref_div}, 32'h7123);

        // R2: clocks with enable high do nothing
        clock_bits(16, 64'h5A5A, 1'b0);
        check("R2", {31'd0, sdo_en}, 32'd0);
        check("R2", {16'd0, fb_div}, {16'd0, m_fb});
        check("R2", jam_cnt, m_jam);
        xfer(8, 64'h3C);
        check("R2", {24'd0, cfg_reg}, 32'h3C);

        // R11a: enable falls while shift clock is high
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sen_n = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        clock_bits(16, 64'h1234, 1'b0);
        sen_n = 1'b1;
        repeat (12) @(negedge clk);
        check("R11", {16'd0, fb_div}, {16'd0, m_fb});
        check("R11", jam_cnt, m_jam);

        // R11b: enable rises while shift clock is high
        sen_n = 1'b0;
        repeat (HALF) @(negedge clk);
        clock_bits(8, 64'hC3, 1'b0);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sen_n = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        repeat (12) @(negedge clk);
        check("R11", {24'd0, cfg_reg}, {24'd0, m_cfg});

        // R11: recovery
        xfer(16, 64'h0000_0000_0000_9F31);
        check("R11", {16'd0, fb_div}, 32'h9F31);

        // R4: strobe never wider than one cycle
        check("R4", jam_wide, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule